// File: doc/BRIEF.md
# Register File with Per-Opcode Port Selection

This block holds the eight 32-bit program registers of a simple sequential processor, together with the decode logic that chooses which registers are read and written for each instruction. Two read ports (A and B) are combinational views of the stored registers. Two write ports (E, which carries the ALU result, and M, which carries the memory result) update the array on the rising clock edge.

Each cycle the surrounding datapath presents the current opcode, the instruction's two register fields, and the two result words. The block works out the source and destination register IDs from those inputs. These IDs include an implicit stack-pointer access for the stack instructions. Any ID at or above 8 means "no access". Such an ID on a read port yields zero. On a write port it suppresses the write.

The design has no sequencing of its own. Its only states are the per-register values, each of which either holds or loads from port M or port E. Port M has priority over port E.

Top module: `rfsel_regfile`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released, every register reads as zero until it is written.
- R2: A write through port E or M takes effect at the rising clock edge. Before that edge, a read port showing the destination register returns the old value. After the edge, it returns the written value.
- R3: A register ID of 8 or more is "no access": a read port given it returns 0, and a write port given it changes no register.
- R4: Opcode encoding is 0 nop, 1 halt, 2 register move, 3 immediate move, 4 store, 5 load, 6 arithmetic op, 7 jump, 8 call, 9 return, 10 push, 11 pop. Read port A uses `ra` for register move, store, arithmetic op and push. It uses the stack pointer for pop and return, and is no access otherwise.
- R5: Read port B uses `rb` for arithmetic op, store and load. It uses the stack pointer for push, pop, call and return, and is no access otherwise.
- R6: Write port E targets `rb` for register move, immediate move and arithmetic op. It targets the stack pointer for push, pop, call and return, and is no access otherwise.
- R7: Write port M targets `ra` for load and pop, and is no access otherwise.
- R8: The stack pointer is register 4. A pop writes `val_m` into `ra` and `val_e` into the stack pointer at the same edge.
- R9: When ports E and M target the same register at one edge, that register takes `val_m`.
- R10: Opcodes 12 to 15 read nothing (both read ports return 0) and write nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| opcode | input | 4 | Instruction opcode, encoded as in R4 |
| ra | input | 4 | First register field of the instruction |
| rb | input | 4 | Second register field of the instruction |
| val_e | input | 32 | ALU result for write port E |
| val_m | input | 32 | Memory result for write port M |
| val_a | output | 32 | Read port A value |
| val_b | output | 32 | Read port B value |

## Verification
The bench sweeps all sixteen opcode values with distinct register fields and distinct result words. After each edge it reads back all eight registers, so a swapped port selection shows up as the wrong register changing or the wrong read value. This covers a source taken from `rb` instead of `ra`, or a missing stack-pointer access. A pop with `ra` equal to the stack pointer forces the two write ports into collision; a design with the wrong priority would leave the ALU word in register 4. Register IDs 8 and 15 are driven on both reads and writes. An implementation that wrapped or truncated the ID would read or corrupt a real register. The bench also samples reads just before the write edge, to catch a design that forwards write data combinationally.

// File: rtl/rfsel_pkg.sv
package rfsel_pkg;

    localparam int WORD_W = 32;
    localparam int NREG   = 8;
    localparam int ID_W   = 4;
    localparam int SP_ID  = 4;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_HALT  = 4'd1,
        OP_RRMOV = 4'd2,
        OP_IRMOV = 4'd3,
        OP_STORE = 4'd4,
        OP_LOAD  = 4'd5,
        OP_ARITH = 4'd6,
        OP_JUMP  = 4'd7,
        OP_CALL  = 4'd8,
        OP_RET   = 4'd9,
        OP_PUSH  = 4'd10,
        OP_POP   = 4'd11
    } opcode_e;

    typedef struct packed {
        logic [ID_W-1:0] src_a;
        logic [ID_W-1:0] src_b;
        logic [ID_W-1:0] dst_e;
        logic [ID_W-1:0] dst_m;
    } port_sel_t;

endpackage

// File: rtl/rfsel_port_select.sv
module rfsel_port_select
    import rfsel_pkg::*;
#(
    parameter int ID_W  = rfsel_pkg::ID_W,
    parameter int NREG  = rfsel_pkg::NREG,
    parameter int SP_ID = rfsel_pkg::SP_ID
) (
    input  logic [3:0]      opcode,
    input  logic [ID_W-1:0] ra,
    input  logic [ID_W-1:0] rb,
    output logic [ID_W-1:0] src_a,
    output logic [ID_W-1:0] src_b,
    output logic [ID_W-1:0] dst_e,
    output logic [ID_W-1:0] dst_m
);

    localparam logic [ID_W-1:0] ID_NONE = ID_W'(NREG);
    localparam logic [ID_W-1:0] ID_SP   = ID_W'(SP_ID);

    port_sel_t sel;

    always_comb begin
        sel = '{src_a: ID_NONE, src_b: ID_NONE, dst_e: ID_NONE, dst_m: ID_NONE};
        unique case (opcode)
            OP_RRMOV: begin
                sel.src_a = ra;
                sel.dst_e = rb;
            end
            OP_IRMOV: begin
                sel.dst_e = rb;
            end
            OP_STORE: begin
                sel.src_a = ra;
                sel.src_b = rb;
            end
            OP_LOAD: begin
                sel.src_b = rb;
                sel.dst_m = ra;
            end
            OP_ARITH: begin
                sel.src_a = ra;
                sel.src_b = rb;
                sel.dst_e = rb;
            end
            OP_CALL: begin
                sel.src_b = ID_SP;
                sel.dst_e = ID_SP;
            end
            OP_RET: begin
                sel.src_a = ID_SP;
                sel.src_b = ID_SP;
                sel.dst_e = ID_SP;
            end
            OP_PUSH: begin
                sel.src_a = ra;
                sel.src_b = ID_SP;
                sel.dst_e = ID_SP;
            end
            OP_POP: begin
                sel.src_a = ID_SP;
                sel.src_b = ID_SP;
                sel.dst_e = ID_SP;
                sel.dst_m = ra;
            end
            default: begin
                sel = '{src_a: ID_NONE, src_b: ID_NONE, dst_e: ID_NONE, dst_m: ID_NONE};
            end
        endcase
    end

    assign src_a = sel.src_a;
    assign src_b = sel.src_b;
    assign dst_e = sel.dst_e;
    assign dst_m = sel.dst_m;

endmodule

// File: rtl/rfsel_storage.sv
module rfsel_storage #(
    parameter int WORD_W = rfsel_pkg::WORD_W,
    parameter int NREG   = rfsel_pkg::NREG,
    parameter int ID_W   = rfsel_pkg::ID_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ID_W-1:0]             dst_e,
    input  logic [ID_W-1:0]             dst_m,
    input  logic [WORD_W-1:0]           val_e,
    input  logic [WORD_W-1:0]           val_m,
    output logic [NREG-1:0][WORD_W-1:0] regs
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic hit_e;
        logic hit_m;

        assign hit_e = (dst_e == ID_W'(i));
        assign hit_m = (dst_m == ID_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (hit_m) begin
                regs[i] <= val_m;
            end else if (hit_e) begin
                regs[i] <= val_e;
            end
        end
    end

endmodule

// File: rtl/rfsel_read_port.sv
module rfsel_read_port #(
    parameter int WORD_W = rfsel_pkg::WORD_W,
    parameter int NREG   = rfsel_pkg::NREG,
    parameter int ID_W   = rfsel_pkg::ID_W
) (
    input  logic [NREG-1:0][WORD_W-1:0] regs,
    input  logic [ID_W-1:0]             id,
    output logic [WORD_W-1:0]           data
);

    always_comb begin
        data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (id == ID_W'(i)) begin
                data = regs[i];
            end
        end
    end

endmodule

// File: rtl/rfsel_regfile.sv
module rfsel_regfile #(
    parameter int WORD_W = rfsel_pkg::WORD_W,
    parameter int NREG   = rfsel_pkg::NREG,
    parameter int ID_W   = rfsel_pkg::ID_W,
    parameter int SP_ID  = rfsel_pkg::SP_ID
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        opcode,
    input  logic [ID_W-1:0]   ra,
    input  logic [ID_W-1:0]   rb,
    input  logic [WORD_W-1:0] val_e,
    input  logic [WORD_W-1:0] val_m,
    output logic [WORD_W-1:0] val_a,
    output logic [WORD_W-1:0] val_b
);

    logic [ID_W-1:0]             src_a;
    logic [ID_W-1:0]             src_b;
    logic [ID_W-1:0]             dst_e;
    logic [ID_W-1:0]             dst_m;
    logic [NREG-1:0][WORD_W-1:0] regs;
    logic [1:0][ID_W-1:0]        rd_id;
    logic [1:0][WORD_W-1:0]      rd_data;

    rfsel_port_select #(.ID_W(ID_W), .NREG(NREG), .SP_ID(SP_ID)) u_sel (
        .opcode (opcode),
        .ra     (ra),
        .rb     (rb),
        .src_a  (src_a),
        .src_b  (src_b),
        .dst_e  (dst_e),
        .dst_m  (dst_m)
    );

    rfsel_storage #(.WORD_W(WORD_W), .NREG(NREG), .ID_W(ID_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .dst_e (dst_e),
        .dst_m (dst_m),
        .val_e (val_e),
        .val_m (val_m),
        .regs  (regs)
    );

    assign rd_id[0] = src_a;
    assign rd_id[1] = src_b;

    for (genvar p = 0; p < 2; p++) begin : g_rd
        rfsel_read_port #(.WORD_W(WORD_W), .NREG(NREG), .ID_W(ID_W)) u_rd (
            .regs (regs),
            .id   (rd_id[p]),
            .data (rd_data[p])
        );
    end

    assign val_a = rd_data[0];
    assign val_b = rd_data[1];

endmodule

// File: rtl/rfsel_checker.sv
module rfsel_checker #(
    parameter int WORD_W = rfsel_pkg::WORD_W,
    parameter int NREG   = rfsel_pkg::NREG,
    parameter int ID_W   = rfsel_pkg::ID_W,
    parameter int SP_ID  = rfsel_pkg::SP_ID
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        opcode,
    input logic [ID_W-1:0]   ra,
    input logic [WORD_W-1:0] val_e,
    input logic [WORD_W-1:0] val_m,
    input logic [WORD_W-1:0] val_a,
    input logic [WORD_W-1:0] val_b,
    input logic [ID_W-1:0]   src_a,
    input logic [ID_W-1:0]   src_b,
    input logic [ID_W-1:0]   dst_e,
    input logic [ID_W-1:0]   dst_m
);

    localparam logic [ID_W-1:0] LIM = ID_W'(NREG);

    AST_M_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_m < LIM) |=> (src_a != $past(dst_m)) || (val_a == $past(val_m))); // R2

    AST_E_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_e < LIM && dst_e != dst_m) |=> (src_a != $past(dst_e)) || (val_a == $past(val_e))); // R2

    AST_M_BEATS_E: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_m < LIM && dst_e == dst_m) |=> (src_b != $past(dst_m)) || (val_b == $past(val_m))); // R9

    AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a >= LIM) |-> (val_a == '0)); // R3

    AST_POP_TWO_DESTS: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd11) |-> (dst_e == ID_W'(SP_ID)) && (dst_m == ra)); // R8

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode >= 4'd12) |-> (val_a == '0) && (val_b == '0) && (dst_e >= LIM) && (dst_m >= LIM)); // R10

endmodule

bind rfsel_regfile rfsel_checker #(
    .WORD_W (WORD_W),
    .NREG   (NREG),
    .ID_W   (ID_W),
    .SP_ID  (SP_ID)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .ra     (ra),
    .val_e  (val_e),
    .val_m  (val_m),
    .val_a  (val_a),
    .val_b  (val_b),
    .src_a  (src_a),
    .src_b  (src_b),
    .dst_e  (dst_e),
    .dst_m  (dst_m)
);

// File: tb/tb_rfsel_regfile.sv
module tb_rfsel_regfile;

    localparam int NONE = 8;
    localparam int SP   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [3:0]  ra = 4'd0;
    logic [3:0]  rb = 4'd0;
    logic [31:0] val_e = '0;
    logic [31:0] val_m = '0;
    logic [31:0] val_a;
    logic [31:0] val_b;

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] model [8];

    always #4 clk = ~clk;

    rfsel_regfile dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .ra     (ra),
        .rb     (rb),
        .val_e  (val_e),
        .val_m  (val_m),
        .val_a  (val_a),
        .val_b  (val_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int exp_src_a(input int op, input int a);
        case (op)
            2, 4, 6, 10: return a;
            9, 11:       return SP;
            default:     return NONE;
        endcase
    endfunction

    function automatic int exp_src_b(input int op, input int b);
        case (op)
            4, 5, 6:       return b;
            8, 9, 10, 11:  return SP;
            default:       return NONE;
        endcase
    endfunction

    function automatic int exp_dst_e(input int op, input int b);
        case (op)
            2, 3, 6:       return b;
            8, 9, 10, 11:  return SP;
            default:       return NONE;
        endcase
    endfunction

    function automatic int exp_dst_m(input int op, input int a);
        case (op)
            5, 11:   return a;
            default: return NONE;
        endcase
    endfunction

    function automatic logic [31:0] mread(input int id);
        return (id < 8) ? model[id] : 32'h0;
    endfunction

    // one clocked instruction; reads checked before the edge, model updated at it
    task automatic exec(input string tag, input int op, input int a, input int b,
                        input logic [31:0] e, input logic [31:0] m);
        int de;
        int dm;
        @(negedge clk);
        opcode = 4'(op); ra = 4'(a); rb = 4'(b); val_e = e; val_m = m;
        #1;
        check({tag, " read A"}, val_a, mread(exp_src_a(op, a)));
        check({tag, " read B"}, val_b, mread(exp_src_b(op, b)));
        de = exp_dst_e(op, b);
        dm = exp_dst_m(op, a);
        @(posedge clk);
        if (de < 8) model[de] = e;
        if (dm < 8) model[dm] = m;
    endtask

    // read every register through the store opcode, which writes nothing
    task automatic peek_all(input string tag);
        for (int i = 0; i < 8; i += 2) begin
            @(negedge clk);
            opcode = 4'd4; ra = 4'(i); rb = 4'(i + 1);
            #1;
            check({tag, " reg"}, val_a, model[i]);
            check({tag, " reg"}, val_b, model[i + 1]);
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) model[i] = '0;
        @(negedge clk);
        opcode = 4'd4; ra = 4'd3; rb = 4'd5;
        #1;
        check("R1 during reset A", val_a, 32'h0);
        check("R1 during reset B", val_b, 32'h0);
        rst_n = 1'b1;
        peek_all("R1 after reset");
    endtask

    task automatic t_preload;
        for (int i = 0; i < 8; i++) exec("R6 immediate move", 3, 0, i, 32'h1000 + i, 32'hBAD0 + i);
        peek_all("R6 preload");
    endtask

    task automatic t_edge_timing;
        @(negedge clk);
        opcode = 4'd6; ra = 4'd1; rb = 4'd2; val_e = 32'hCAFE0002; val_m = 32'h0;
        #1;
        check("R2 old value before edge", val_b, model[2]);
        @(posedge clk);
        #1;
        check("R2 new value after edge", val_b, 32'hCAFE0002);
        model[2] = 32'hCAFE0002;
    endtask

    task automatic t_opcode_sweep;
        for (int op = 0; op < 16; op++) begin
            exec($sformatf("R4 R5 R6 R7 R10 opcode %0d", op), op, 1, 2,
                 32'hE0000000 + op, 32'hD0000000 + op);
            peek_all($sformatf("R6 R7 R10 after opcode %0d", op));
        end
    endtask

    task automatic t_pop_sp;
        exec("R8 pop", 11, 6, 0, 32'h00005004, 32'h0000A006);
        peek_all("R8 pop two writes");
        check("R8 sp", model[SP], 32'h00005004);
    endtask

    task automatic t_priority;
        exec("R9 pop into sp", 11, SP, 0, 32'h11111111, 32'h22222222);
        peek_all("R9 M over E");
        check("R9 sp holds memory word", model[SP], 32'h22222222);
    endtask

    task automatic t_none_id;
        exec("R3 none reads", 4, 8, 15, 32'h0, 32'h0);
        exec("R3 none write E", 3, 0, 8, 32'h33333333, 32'h0);
        exec("R3 none write M", 5, 15, 9, 32'h0, 32'h44444444);
        exec("R3 none arith", 6, 9, 12, 32'h55555555, 32'h0);
        peek_all("R3 no register changed");
    endtask

    initial begin
        t_reset();
        t_preload();
        t_edge_timing();
        t_opcode_sweep();
        t_pop_sp();
        t_priority();
        t_none_id();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule